// File: doc/BRIEF.md
# Multi-mode ADC Conversion Sequencer

This block steps an external analog-to-digital converter core through its conversions. Software writes a configuration word made of a 2-bit mode, a channel number and a start bit. The block then sends one conversion request per channel to the core, waits for the core's done strobe, and stores each result together with the channel it came from. It pulses an end-of-conversion interrupt and flags an overrun when an unread result is overwritten.

There are four modes. A fixed-channel conversion runs once or repeatedly. A descending scan runs from the selected channel down to channel 0, once or repeatedly. Configuration writes that arrive while a conversion is running do not disturb it. The mode is held back until the running conversion ends. The channel and start bit are held back until the end of that conversion in fixed mode, or until channel 0 has been converted in scan mode. A write made while idle without the start bit only stores the configuration and never begins a conversion.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, busy, conv_req, eoc_irq and overrun are 0, and res_data and res_chan are 0.
- R2: Mode field encoding: 2'b00 fixed single, 2'b01 fixed continuous, 2'b10 single scan, 2'b11 continuous scan. An idle write of mode 2'b00 with start=1 converts the written channel exactly once and then returns to idle.
- R3: An idle write with start=0 starts no conversion in any mode, including both scan modes. busy stays 0 and conv_req never rises.
- R4: Single scan (2'b10) started on channel n converts channels n, n-1, ..., 0 in that order and then goes idle.
- R5: The continuous modes restart by themselves. Fixed continuous (2'b01) repeats the same channel. Continuous scan (2'b11) restarts from the selected channel after channel 0. Both stop at the next boundary after start=0 is written.
- R6: busy is 1 from the cycle after a starting write until the cycle after the done strobe of the last conversion of the sequence, and 0 otherwise.
- R7: A mode written while busy takes effect only after the running conversion. A switch to a scan mode written during a fixed conversion of channel n makes channels n-1 down to 0 the next conversions.
- R8: A channel or start bit written while busy takes effect after the running conversion in fixed mode, and only after channel 0 has been converted in a scan mode.
- R9: Each finished conversion loads res_data with the core data and res_chan with its channel, and drives eoc_irq high for exactly the one cycle after the done strobe.
- R10: overrun becomes 1 when a result is stored while the previous result has not been acknowledged with res_rd. A res_rd pulse clears overrun.
- R11: conv_req is a one-cycle pulse, valid together with conv_chan. No new request is issued until the core's conv_done strobe has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode field of the written word |
| cfg_chan | input | CH_W | Channel field of the written word |
| cfg_start | input | 1 | Start bit of the written word |
| res_rd | input | 1 | Result acknowledge, clears the overrun flag |
| conv_done | input | 1 | Core strobe: conversion finished, data valid |
| conv_data | input | DATA_W | Core conversion data |
| busy | output | 1 | Conversion or sequence in progress |
| conv_req | output | 1 | One-cycle conversion request to the core |
| conv_chan | output | CH_W | Channel of the current request |
| res_data | output | DATA_W | Last stored result |
| res_chan | output | CH_W | Channel of the last stored result |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |
| overrun | output | 1 | Unread result was overwritten |

## Verification
The bench records the channel of every request, so each scenario can be compared against an exact channel sequence rather than a single end state. The cases are:

- A lone fixed conversion and a descending scan separate a one-shot run from a walk to channel 0.
- Idle writes without the start bit in both scan modes show that storing a configuration alone never starts a conversion.
- Continuous runs stopped at a known point separate stopping at a conversion boundary from stopping at the end of a scan.
- A switch to scan written during a fixed conversion, and a new channel with start written in the middle of a scan, show which fields are held back and until when.
- Two results left unread and then acknowledged show both the setting and the clearing of the overrun flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MD_FIX_ONE  = 2'b00,
    MD_FIX_RUN  = 2'b01,
    MD_SCAN_ONE = 2'b10,
    MD_SCAN_RUN = 2'b11
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_WAIT = 2'b10
  } seq_state_e;

  function automatic logic mode_is_scan(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_cont(input logic [1:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_mode,
  input  logic [CH_W-1:0] wr_chan,
  input  logic            wr_start,
  input  logic            busy,
  input  logic            conv_fin,
  input  logic [CH_W-1:0] cur_chan,
  output logic            launch,
  output logic [CH_W-1:0] launch_chan,
  output logic            advance,
  output logic [CH_W-1:0] advance_chan
);

  // live configuration
  logic [1:0]      mode_q, mode_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic            start_q, start_d;
  // deferred fields written while busy
  logic            pm_v_q, pm_v_d;
  logic [1:0]      pm_q, pm_d;
  logic            pcs_v_q, pcs_v_d;
  logic [CH_W-1:0] pc_q, pc_d;
  logic            ps_q, ps_d;

  logic            idle_wr, busy_wr;
  logic [1:0]      new_mode;
  logic            walk, restart, latch_cs;
  logic [CH_W-1:0] chan_n;
  logic            start_n;

  always_comb begin
    idle_wr     = wr_en && !busy;
    busy_wr     = wr_en && busy;
    launch      = idle_wr && wr_start;
    launch_chan = wr_chan;

    new_mode = pm_v_q ? pm_q : mode_q;
    chan_n   = pcs_v_q ? pc_q : chan_q;
    start_n  = pcs_v_q ? ps_q : start_q;

    // keep descending while the effective mode is a scan and channel 0 is not reached
    walk     = mode_is_scan(new_mode) && (cur_chan != '0);
    restart  = pcs_v_q ? ps_q : (start_q && mode_is_cont(new_mode));
    latch_cs = conv_fin && (!mode_is_scan(mode_q) || !walk);

    advance      = walk || restart;
    advance_chan = walk ? CH_W'(cur_chan - 1'b1) : chan_n;
  end

  always_comb begin
    mode_d  = mode_q;
    chan_d  = chan_q;
    start_d = start_q;
    pm_v_d  = pm_v_q;
    pm_d    = pm_q;
    pcs_v_d = pcs_v_q;
    pc_d    = pc_q;
    ps_d    = ps_q;

    if (idle_wr) begin
      mode_d  = wr_mode;
      chan_d  = wr_chan;
      start_d = wr_start;
      pm_v_d  = 1'b0;
      pcs_v_d = 1'b0;
    end else if (conv_fin) begin
      mode_d = new_mode;
      pm_v_d = 1'b0;
      if (latch_cs) begin
        chan_d  = chan_n;
        start_d = walk ? start_n : restart;
        pcs_v_d = 1'b0;
      end
    end

    if (busy_wr) begin
      pm_v_d  = 1'b1;
      pm_d    = wr_mode;
      pcs_v_d = 1'b1;
      pc_d    = wr_chan;
      ps_d    = wr_start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_FIX_ONE;
      chan_q  <= '0;
      start_q <= 1'b0;
      pm_v_q  <= 1'b0;
      pm_q    <= MD_FIX_ONE;
      pcs_v_q <= 1'b0;
      pc_q    <= '0;
      ps_q    <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      chan_q  <= chan_d;
      start_q <= start_d;
      pm_v_q  <= pm_v_d;
      pm_q    <= pm_d;
      pcs_v_q <= pcs_v_d;
      pc_q    <= pc_d;
      ps_q    <= ps_d;
    end
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [CH_W-1:0] launch_chan,
  input  logic            advance,
  input  logic [CH_W-1:0] advance_chan,
  input  logic            conv_done,
  output logic            conv_req,
  output logic [CH_W-1:0] cur_chan,
  output logic            busy,
  output logic            conv_fin
);

  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] chan_q, chan_d;

  always_comb begin
    state_d  = state_q;
    chan_d   = chan_q;
    conv_fin = (state_q == ST_WAIT) && conv_done;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d = ST_REQ;
          chan_d  = launch_chan;
        end
      end
      ST_REQ: state_d = ST_WAIT;
      ST_WAIT: begin
        if (conv_done) begin
          if (advance) begin
            state_d = ST_REQ;
            chan_d  = advance_chan;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
    end
  end

  assign conv_req = (state_q == ST_REQ);
  assign busy     = (state_q != ST_IDLE);
  assign cur_chan = chan_q;

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_fin,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [CH_W-1:0]   cur_chan,
  input  logic              res_rd,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_chan,
  output logic              eoc_irq,
  output logic              overrun
);

  logic              unread_q, unread_d;
  logic              ovr_q, ovr_d;
  logic [DATA_W-1:0] data_q;
  logic [CH_W-1:0]   chan_q;
  logic              irq_q;

  always_comb begin
    unread_d = unread_q;
    ovr_d    = ovr_q;
    if (conv_fin) begin
      unread_d = 1'b1;
      if (unread_q && !res_rd) ovr_d = 1'b1;
      else if (res_rd)         ovr_d = 1'b0;
    end else if (res_rd) begin
      unread_d = 1'b0;
      ovr_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unread_q <= 1'b0;
      ovr_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      unread_q <= unread_d;
      ovr_q    <= ovr_d;
      irq_q    <= conv_fin;
    end
  end

  // result register with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      chan_q <= '0;
    end else if (conv_fin) begin
      data_q <= conv_data;
      chan_q <= cur_chan;
    end
  end

  assign res_data = data_q;
  assign res_chan = chan_q;
  assign eoc_irq  = irq_q;
  assign overrun  = ovr_q;

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              cfg_start,
  input  logic              res_rd,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              busy,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_chan,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_chan,
  output logic              eoc_irq,
  output logic              overrun
);

  logic            launch, advance, conv_fin;
  logic [CH_W-1:0] launch_chan, advance_chan, cur_chan;

  adc_seq_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_we),
    .wr_mode      (cfg_mode),
    .wr_chan      (cfg_chan),
    .wr_start     (cfg_start),
    .busy         (busy),
    .conv_fin     (conv_fin),
    .cur_chan     (cur_chan),
    .launch       (launch),
    .launch_chan  (launch_chan),
    .advance      (advance),
    .advance_chan (advance_chan)
  );

  adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .launch_chan  (launch_chan),
    .advance      (advance),
    .advance_chan (advance_chan),
    .conv_done    (conv_done),
    .conv_req     (conv_req),
    .cur_chan     (cur_chan),
    .busy         (busy),
    .conv_fin     (conv_fin)
  );

  adc_seq_result #(.CH_W(CH_W), .DATA_W(DATA_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_fin  (conv_fin),
    .conv_data (conv_data),
    .cur_chan  (cur_chan),
    .res_rd    (res_rd),
    .res_data  (res_data),
    .res_chan  (res_chan),
    .eoc_irq   (eoc_irq),
    .overrun   (overrun)
  );

  assign conv_chan = cur_chan;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_start,
  input logic              res_rd,
  input logic              conv_done,
  input logic              busy,
  input logic              conv_req,
  input logic [CH_W-1:0]   conv_chan,
  input logic [DATA_W-1:0] conv_data,
  input logic [DATA_W-1:0] res_data,
  input logic [CH_W-1:0]   res_chan,
  input logic              eoc_irq,
  input logic              overrun
);

  // R11
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  // R3
  idle_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cfg_we && cfg_start)) |=> (!busy && !conv_req));

  // R9
  done_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_req && conv_done) |=> (eoc_irq && res_data == $past(conv_data)
                                          && res_chan == $past(conv_chan)));

  // R7
  busy_write_defers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we && !conv_done) |=> busy);

  // R10
  overrun_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(conv_done));

  // R10
  overrun_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && !conv_done) |=> !overrun);

endmodule

bind adc_conv_sequencer adc_seq_chk #(.CH_W(CH_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_start (cfg_start),
  .res_rd    (res_rd),
  .conv_done (conv_done),
  .busy      (busy),
  .conv_req  (conv_req),
  .conv_chan (conv_chan),
  .conv_data (conv_data),
  .res_data  (res_data),
  .res_chan  (res_chan),
  .eoc_irq   (eoc_irq),
  .overrun   (overrun)
);

// File: tb/tb_adc_conv_sequencer.sv
module tb_adc_conv_sequencer;
  localparam int CH_W   = 3;
  localparam int DATA_W = 10;

  logic              clk, rst_n;
  logic              cfg_we, cfg_start, res_rd;
  logic [1:0]        cfg_mode;
  logic [CH_W-1:0]   cfg_chan;
  logic              conv_done;
  logic [DATA_W-1:0] conv_data;
  logic              busy, conv_req, eoc_irq, overrun;
  logic [CH_W-1:0]   conv_chan, res_chan;
  logic [DATA_W-1:0] res_data;

  int n_run, n_fail;
  int nlog, nirq, dbl;
  int log_ch [0:63];
  logic prev_req;
  int cnt;
  logic [CH_W-1:0] ch_l;

  adc_conv_sequencer #(.CH_W(CH_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_chan(cfg_chan), .cfg_start(cfg_start), .res_rd(res_rd),
    .conv_done(conv_done), .conv_data(conv_data), .busy(busy),
    .conv_req(conv_req), .conv_chan(conv_chan), .res_data(res_data),
    .res_chan(res_chan), .eoc_irq(eoc_irq), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // converter core model and monitors
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 0; ch_l <= '0; conv_done <= 1'b0; conv_data <= '0;
      nlog <= 0; nirq <= 0; dbl <= 0; prev_req <= 1'b0;
    end else begin
      if (conv_req) begin
        cnt  <= 3;
        ch_l <= conv_chan;
        if (nlog < 64) log_ch[nlog] <= int'(conv_chan);
        nlog <= nlog + 1;
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
      end
      conv_done <= (cnt == 1);
      conv_data <= DATA_W'(int'(ch_l) * 7 + 100);
      if (eoc_irq) nirq <= nirq + 1;
      prev_req <= conv_req;
      if (conv_req && prev_req) dbl <= dbl + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] m, input int ch, input logic st);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = m; cfg_chan = CH_W'(ch); cfg_start = st;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ack;
    @(negedge clk); res_rd = 1'b1;
    @(negedge clk); res_rd = 1'b0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 2000 && nlog < n; i++) @(negedge clk);
  endtask

  task automatic chk_seq(input int base, input int exp[], input string req);
    chk(nlog - base == exp.size(), req, nlog - base, exp.size());
    foreach (exp[i])
      if (base + i < nlog && base + i < 64)
        chk(log_ch[base + i] == exp[i], req, log_ch[base + i], exp[i]);
  endtask

  task automatic t_reset;
    chk(!busy && !conv_req, "R1", int'(busy) + int'(conv_req), 0);
    chk(!eoc_irq && !overrun, "R1", int'(eoc_irq) + int'(overrun), 0);
    chk(res_data == 0 && res_chan == 0, "R1", int'(res_data), 0);
  endtask

  task automatic t_fixed_single;
    int b, q;
    ack();
    b = nlog; q = nirq;
    write_cfg(2'b00, 5, 1'b1);
    chk(busy == 1'b1, "R6", int'(busy), 1);
    wait_idle();
    repeat (4) @(negedge clk);
    chk_seq(b, '{5}, "R2");
    chk(res_chan == 5 && res_data == 135, "R9", int'(res_data), 135);
    chk(nirq - q == 1, "R9", nirq - q, 1);
    chk(!busy, "R6", int'(busy), 0);
  endtask

  task automatic t_no_start;
    int b;
    b = nlog;
    write_cfg(2'b10, 4, 1'b0);
    repeat (30) @(negedge clk);
    write_cfg(2'b11, 6, 1'b0);
    repeat (30) @(negedge clk);
    chk(nlog == b && !busy, "R3", nlog - b, 0);
  endtask

  task automatic t_scan_single;
    int b, q;
    ack();
    b = nlog; q = nirq;
    write_cfg(2'b10, 3, 1'b1);
    wait_idle();
    repeat (4) @(negedge clk);
    chk_seq(b, '{3, 2, 1, 0}, "R4");
    chk(nirq - q == 4, "R9", nirq - q, 4);
    chk(res_chan == 0 && res_data == 100, "R9", int'(res_data), 100);
  endtask

  task automatic t_fixed_cont;
    int b;
    b = nlog;
    write_cfg(2'b01, 2, 1'b1);
    wait_log(b + 3);
    write_cfg(2'b01, 2, 1'b0);
    chk(busy == 1'b1, "R8", int'(busy), 1);
    wait_idle();
    repeat (10) @(negedge clk);
    chk_seq(b, '{2, 2, 2}, "R5");
  endtask

  task automatic t_scan_cont;
    int b;
    b = nlog;
    write_cfg(2'b11, 2, 1'b1);
    wait_log(b + 4);
    write_cfg(2'b11, 2, 1'b0);
    wait_idle();
    repeat (10) @(negedge clk);
    chk_seq(b, '{2, 1, 0, 2, 1, 0}, "R5");
  endtask

  task automatic t_mode_switch;
    int b;
    b = nlog;
    write_cfg(2'b00, 4, 1'b1);
    wait_log(b + 1);
    write_cfg(2'b10, 6, 1'b0);
    wait_idle();
    repeat (10) @(negedge clk);
    chk_seq(b, '{4, 3, 2, 1, 0}, "R7");
  endtask

  task automatic t_scan_defer;
    int b;
    b = nlog;
    write_cfg(2'b10, 3, 1'b1);
    wait_log(b + 1);
    write_cfg(2'b10, 1, 1'b1);
    wait_idle();
    repeat (10) @(negedge clk);
    chk_seq(b, '{3, 2, 1, 0, 1, 0}, "R8");
  endtask

  task automatic t_overrun;
    ack();
    write_cfg(2'b00, 1, 1'b1);
    wait_idle(); repeat (3) @(negedge clk);
    chk(!overrun, "R10", int'(overrun), 0);
    write_cfg(2'b00, 6, 1'b1);
    wait_idle(); repeat (3) @(negedge clk);
    chk(overrun == 1'b1, "R10", int'(overrun), 1);
    chk(res_chan == 6 && res_data == 142, "R9", int'(res_data), 142);
    ack();
    @(negedge clk);
    chk(!overrun, "R10", int'(overrun), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    cfg_we = 0; cfg_mode = 2'b00; cfg_chan = '0; cfg_start = 0; res_rd = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed_single();
    t_no_start();
    t_scan_single();
    t_fixed_cont();
    t_scan_cont();
    t_mode_switch();
    t_scan_defer();
    t_overrun();
    chk(dbl == 0, "R11", dbl, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule